// File: doc/BRIEF.md
# Two-Wire Serial Bus Primitive Engine

This block drives an open-drain two-wire serial bus (clock line and data line) for a host that wants to run the bus one primitive at a time. The host issues a single command. The engine then runs one low-level bus action on its own: a START condition, a STOP condition, shifting out one byte, sampling the acknowledge bit, or shifting in one byte and answering it with ACK or NACK. Addressing, register access and transaction ordering are left to the host, which chains these primitives itself.

Both lines are modelled as pull-low enables: a 1 on `sclOe` or `sdaOe` pulls the line low, and a 0 releases it to the external pull-up. The engine reads the resolved data line on `sdaIn`. All phase timing is counted in system clock cycles. One time unit U equals CLK_HZ / 1,000,000 cycles, or 1 cycle when that quotient is below 1. A phase with a zero-length delay lasts one cycle. After reset the engine releases both lines and runs a STOP on its own, so that every device on the bus starts from a known state.

Top module: `i2cp_engine`

## Requirements
- R1: While reset is asserted, both lines are released and `done` is low. `busy` stays high from reset until an automatic STOP completes. The STOP lasts 8U+1 cycles after the first clock edge out of reset, produces a STOP condition on the bus, and never pulses `done`.
- R2: Command code 1 (START) releases both lines for 4U cycles, then pulls the data line low for 4U cycles with the clock line high, then pulls the clock line low. `done` rises 8U+1 cycles after the accepting edge.
- R3: Command code 2 (STOP) pulls the data line low for 4U cycles, then releases the clock line for 4U cycles, then releases the data line, so the data line rises while the clock line is high. `done` rises 8U+1 cycles after the accepting edge.
- R4: Command code 3 (WRITE) sends `txByte` most significant bit first. Each bit takes three 2U phases: set the data line, raise the clock, lower the clock. The data line never changes while the clock line stays high. `done` rises 48U cycles after the accepting edge. No acknowledge is handled.
- R5: Command code 4 (ACKCHK) releases the data line for U, raises the clock for U, samples the data line at the end of that high phase, and then lowers the clock for U. `ackStatus` becomes 1 when the line was high (NACK) and 0 when it was low (ACK). `done` rises 3U cycles after the accepting edge.
- R6: Command code 5 (READ) runs 8 clocks. Each has a 2U low phase with the data line released and a U high phase, sampled at the end of the high phase. The bits are shifted in so that the first bit received lands in bit 7 of `rxByte`. A ninth clock with three 2U phases then drives the data line low when `ackSel`=1 (ACK) or leaves it released when `ackSel`=0 (NACK). `done` rises 30U cycles after the accepting edge.
- R7: A command is taken on a clock edge only when `cmdValid` is high, `busy` is low and `cmdCode` is 1 to 5. Codes 0, 6 and 7, and any command presented while busy, are ignored and leave no trace. `done` is a one-cycle pulse, and `busy` is low in the cycle in which `done` is high.
- R8: `rxByte` changes only when a READ completes, and `ackStatus` changes only during an ACKCHK. Both hold their values through every other command and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request strobe |
| cmdCode | input | 3 | Primitive select: 1 START, 2 STOP, 3 WRITE, 4 ACKCHK, 5 READ |
| txByte | input | 8 | Byte sent by WRITE, captured when the command is accepted |
| ackSel | input | 1 | Ninth-clock answer for READ: 1 sends ACK, 0 sends NACK |
| busy | output | 1 | A primitive (or the reset STOP) is in progress |
| done | output | 1 | One-cycle completion pulse of a host command |
| rxByte | output | 8 | Last byte received by READ |
| ackStatus | output | 1 | Last sampled acknowledge: 1 NACK, 0 ACK |
| sclOe | output | 1 | Pulls the clock line low when 1 |
| sdaOe | output | 1 | Pulls the data line low when 1 |
| sdaIn | input | 1 | Resolved level of the data line |

## Verification
Every primitive has a fixed length: 8U+1 cycles for START and STOP, 48U for WRITE, 3U for ACKCHK and 30U for READ. The bench drives a command on a falling edge, so the next rising edge accepts it. At each falling edge after that it expects `busy` high and `done` low until exactly that many cycles have passed, and then `done` high with `busy` low. Bus-level results are judged at the falling edge where `done` is seen: the START/STOP counts, the byte collected on clock rises, the data a target model latched, `rxByte` and `ackStatus`. A bus monitor samples both lines at every falling edge. It flags any data-line change made while the clock line is high during a byte or acknowledge primitive.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;

  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_START  = 3'd1,
    CMD_STOP   = 3'd2,
    CMD_WRITE  = 3'd3,
    CMD_ACKCHK = 3'd4,
    CMD_READ   = 3'd5
  } cmd_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic sclSet;
    logic sclLow;
    logic sdaSet;
    logic sdaLow;
    logic sdaTx;
    logic loadTx;
    logic rxSample;
    logic ackSample;
    logic rxCommit;
  } strobe_t;

  function automatic logic isCmd(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd5);
  endfunction

endpackage

// File: rtl/i2cp_datapath.sv
module i2cp_datapath import i2cp_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] txByte,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic [BYTE_W-1:0] rxByte,
  output logic              ackStatus
);

  logic [BYTE_W-1:0] txSh;
  logic [BYTE_W-1:0] rxSh;
  logic [BYTE_W-1:0] txSrc;

  assign txSrc = stb.loadTx ? txByte : txSh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclOe     <= 1'b0;
      sdaOe     <= 1'b0;
      txSh      <= '0;
      rxSh      <= '0;
      rxByte    <= '0;
      ackStatus <= 1'b0;
    end else begin
      if (stb.sclSet) sclOe <= stb.sclLow;
      if (stb.sdaSet) sdaOe <= stb.sdaLow;
      if (stb.sdaTx) begin
        sdaOe <= ~txSrc[BYTE_W-1];
        txSh  <= {txSrc[BYTE_W-2:0], 1'b0};
      end else if (stb.loadTx) begin
        txSh <= txByte;
      end
      if (stb.rxSample)  rxSh      <= {rxSh[BYTE_W-2:0], sdaIn};
      if (stb.ackSample) ackStatus <= sdaIn;
      if (stb.rxCommit)  rxByte    <= rxSh;
    end
  end

endmodule

// File: rtl/i2cp_ctrl.sv
module i2cp_ctrl import i2cp_pkg::*; #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       ackSel,
  output strobe_t    stb,
  output cmd_e       curCmd,
  output logic       busy,
  output logic       done
);

  localparam int US = (CLK_HZ >= 2_000_000) ? (CLK_HZ / 1_000_000) : 1;
  localparam int TW = $clog2(4 * US + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_PRIME, ST_RUN} state_e;

  state_e           state;
  cmd_e             cmdR;
  logic [BIT_W-1:0] bitR, nextBit;
  logic [1:0]       phR, nextPh, lastPh;
  logic [TW-1:0]    timer, lenM1;
  logic             ackSelR, autoR, endStep, finish;

  // line action applied on entry to phase p of bit b
  function automatic strobe_t stepAct(input cmd_e c, input logic [BIT_W-1:0] b,
                                      input logic [1:0] p, input logic ak);
    strobe_t s;
    s = '0;
    case (c)
      CMD_START: case (p)
        2'd0:    begin s.sclSet = 1'b1; s.sdaSet = 1'b1; end
        2'd1:    begin s.sdaSet = 1'b1; s.sdaLow = 1'b1; end
        default: begin s.sclSet = 1'b1; s.sclLow = 1'b1; end
      endcase
      CMD_STOP: case (p)
        2'd0:    begin s.sdaSet = 1'b1; s.sdaLow = 1'b1; end
        2'd1:    s.sclSet = 1'b1;
        default: s.sdaSet = 1'b1;
      endcase
      CMD_WRITE: case (p)
        2'd0:    s.sdaTx = 1'b1;
        2'd1:    s.sclSet = 1'b1;
        default: begin s.sclSet = 1'b1; s.sclLow = 1'b1; end
      endcase
      CMD_ACKCHK: case (p)
        2'd0:    s.sdaSet = 1'b1;
        2'd1:    s.sclSet = 1'b1;
        default: begin s.sclSet = 1'b1; s.sclLow = 1'b1; end
      endcase
      CMD_READ: begin
        if (b < BIT_W'(BYTE_W)) begin
          if (p == 2'd0) begin s.sclSet = 1'b1; s.sclLow = 1'b1; s.sdaSet = 1'b1; end
          else s.sclSet = 1'b1;
        end else case (p)
          2'd0:    begin s.sclSet = 1'b1; s.sclLow = 1'b1; s.sdaSet = 1'b1; s.sdaLow = ak; end
          2'd1:    s.sclSet = 1'b1;
          default: begin s.sclSet = 1'b1; s.sclLow = 1'b1; end
        endcase
      end
      default: ;
    endcase
    return s;
  endfunction

  // phase length in microsecond units (0 means one cycle)
  function automatic int stepUnits(input cmd_e c, input logic [BIT_W-1:0] b, input logic [1:0] p);
    case (c)
      CMD_START, CMD_STOP: return (p == 2'd2) ? 0 : 4;
      CMD_WRITE:           return 2;
      CMD_ACKCHK:          return 1;
      CMD_READ:            return ((b < BIT_W'(BYTE_W)) && (p == 2'd1)) ? 1 : 2;
      default:             return 1;
    endcase
  endfunction

  always_comb begin
    int u;
    u       = stepUnits(cmdR, bitR, phR);
    lenM1   = (u == 0) ? '0 : TW'(u * US - 1);
    lastPh  = ((cmdR == CMD_READ) && (bitR < BIT_W'(BYTE_W))) ? 2'd1 : 2'd2;
    finish  = (phR == lastPh) &&
              ((cmdR == CMD_WRITE) ? (bitR == BIT_W'(BYTE_W - 1)) :
               (cmdR == CMD_READ)  ? (bitR == BIT_W'(BYTE_W)) : 1'b1);
    nextBit = (phR == lastPh) ? bitR + BIT_W'(1) : bitR;
    nextPh  = (phR == lastPh) ? 2'd0 : phR + 2'd1;
    endStep = (state == ST_RUN) && (timer == lenM1);

    stb = '0;
    case (state)
      ST_IDLE: if (cmdValid && isCmd(cmdCode)) begin
        stb        = stepAct(cmd_e'(cmdCode), '0, 2'd0, ackSel);
        stb.loadTx = 1'b1;
      end
      ST_PRIME: stb = stepAct(CMD_STOP, '0, 2'd0, 1'b0);
      default: if (endStep) begin
        stb.ackSample = (cmdR == CMD_ACKCHK) && (phR == 2'd1);
        stb.rxSample  = (cmdR == CMD_READ) && (bitR < BIT_W'(BYTE_W)) && (phR == 2'd1);
        if (finish) stb.rxCommit = (cmdR == CMD_READ);
        else        stb = strobe_t'(stb | stepAct(cmdR, nextBit, nextPh, ackSelR));
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_PRIME;
      cmdR    <= CMD_STOP;
      bitR    <= '0;
      phR     <= 2'd0;
      timer   <= '0;
      ackSelR <= 1'b0;
      autoR   <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (cmdValid && isCmd(cmdCode)) begin
          state   <= ST_RUN;
          cmdR    <= cmd_e'(cmdCode);
          bitR    <= '0;
          phR     <= 2'd0;
          timer   <= '0;
          ackSelR <= ackSel;
          autoR   <= 1'b0;
        end
        ST_PRIME: begin
          state <= ST_RUN;
          timer <= '0;
        end
        default: if (endStep) begin
          timer <= '0;
          if (finish) begin
            state <= ST_IDLE;
            done  <= ~autoR;
          end else begin
            bitR <= nextBit;
            phR  <= nextPh;
          end
        end else begin
          timer <= timer + TW'(1);
        end
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign curCmd = cmdR;

  // R7: a single completion pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);

endmodule

// File: rtl/i2cp_engine.sv
module i2cp_engine import i2cp_pkg::*; #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [2:0]  cmdCode,
  input  logic [7:0]  txByte,
  input  logic        ackSel,
  output logic        busy,
  output logic        done,
  output logic [7:0]  rxByte,
  output logic        ackStatus,
  output logic        sclOe,
  output logic        sdaOe,
  input  logic        sdaIn
);

  strobe_t stb;
  cmd_e    curCmd;
  logic    byteCmd;

  i2cp_ctrl #(.CLK_HZ(CLK_HZ)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .ackSel(ackSel), .stb(stb), .curCmd(curCmd), .busy(busy), .done(done)
  );

  i2cp_datapath uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .txByte(txByte), .sdaIn(sdaIn),
    .sclOe(sclOe), .sdaOe(sdaOe), .rxByte(rxByte), .ackStatus(ackStatus)
  );

  assign byteCmd = (curCmd == CMD_WRITE) || (curCmd == CMD_READ) || (curCmd == CMD_ACKCHK);

  // R4: data line held while the clock line stays released in byte primitives
  a_r4_sda_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && byteCmd && !sclOe && $past(!sclOe)) |-> $stable(sdaOe));

  // R7: done never overlaps busy
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);

  // R8: results hold while idle
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> ($stable(rxByte) && $stable(ackStatus)));

endmodule

// File: tb/sim_i2cp_engine.sv
module sim_i2cp_engine;

  localparam int CLK_HZ = 4_000_000;
  localparam int U      = CLK_HZ / 1_000_000;
  localparam int D_SS   = 8 * U + 1;
  localparam int D_WR   = 48 * U;
  localparam int D_ACK  = 3 * U;
  localparam int D_RD   = 30 * U;
  localparam logic [6:0] TGT_ADDR = 7'h52;
  localparam logic [7:0] TGT_DATA = 8'hC9;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdCode = 3'd0;
  logic [7:0] txByte = 8'h00;
  logic       ackSel = 1'b0;
  logic       busy, done, ackStatus, sclOe, sdaOe, sdaIn;
  logic [7:0] rxByte;
  logic       tPull = 1'b0;

  wire sclLine = ~sclOe;
  wire sdaLine = ~sdaOe & ~tPull;
  assign sdaIn = sdaLine;

  i2cp_engine #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .txByte(txByte), .ackSel(ackSel), .busy(busy), .done(done),
    .rxByte(rxByte), .ackStatus(ackStatus), .sclOe(sclOe), .sdaOe(sdaOe),
    .sdaIn(sdaIn)
  );

  int checks = 0, bad = 0;
  bit finished = 1'b0;

  // bus monitor and target state
  int   startCnt = 0, stopCnt = 0, stabBad = 0;
  logic prevScl = 1'b1, prevSda = 1'b1;
  logic [7:0] monByte = 8'h00;
  bit   byteCmd = 1'b0;
  int   tMode = 0, tCnt = 0;
  logic [7:0] tSh = 8'h00, tGot = 8'h00;
  logic mAck = 1'b0;
  bit   lastData = 1'b0;
  int   doneSeen = 0;

  always @(negedge clk) begin
    logic sc, sd;
    sc = sclLine;
    sd = sdaLine;
    if (done) doneSeen++;
    if (prevScl && sc) begin
      if (prevSda && !sd) begin startCnt++; tMode = 1; tCnt = 0; tPull = 1'b0; end
      else if (!prevSda && sd) begin stopCnt++; tMode = 0; tPull = 1'b0; end
      if ((sd != prevSda) && byteCmd) stabBad++;
    end
    if (!prevScl && sc) begin
      monByte = {monByte[6:0], sd};
      tCnt++;
      if (tMode != 0) begin
        if (tCnt <= 8 && tMode != 3) tSh = {tSh[6:0], sd};
        if (tCnt == 9) mAck = sd;
      end
    end
    if (prevScl && !sc && tMode != 0) begin
      if (tCnt == 8) begin
        case (tMode)
          1: if (tSh[7:1] == TGT_ADDR) begin
               tPull = 1'b1; tMode = tSh[0] ? 3 : 2; lastData = 1'b0;
             end else begin
               tPull = 1'b0; tMode = 0;
             end
          2: begin tPull = 1'b1; tGot = tSh; end
          default: tPull = 1'b0;
        endcase
      end else if (tCnt == 9) begin
        tCnt = 0;
        if (tMode == 3 && !(lastData && mAck)) begin
          tPull = !TGT_DATA[7]; lastData = 1'b1;
        end else begin
          tPull = 1'b0;
          if (tMode == 3) tMode = 0;
        end
      end else if (tMode == 3 && tCnt >= 1 && tCnt <= 7) begin
        tPull = !TGT_DATA[7 - tCnt];
      end
    end
    prevScl = sc;
    prevSda = sdaLine;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one command and compare busy/done against the expected length on every clock
  task automatic runCmd(input logic [2:0] code, input logic [7:0] b, input logic ak,
                        input int dur, input string tag);
    int misses;
    misses = 0;
    @(negedge clk);
    byteCmd  = (code == 3'd3) || (code == 3'd4) || (code == 3'd5);
    cmdValid = 1'b1; cmdCode = code; txByte = b; ackSel = ak;
    @(negedge clk);
    cmdValid = 1'b0;
    for (int k = 0; k <= dur; k++) begin
      if (k < dur) begin
        if (!(busy && !done)) misses++;
        @(negedge clk);
      end else begin
        if (!(done && !busy)) misses++;
      end
    end
    check(misses == 0, tag, misses, 0);
    byteCmd = 1'b0;
  endtask

  initial begin
    int cnt, s0, p0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!sclOe && !sdaOe && !done, "R1 lines released in reset", {sclOe, sdaOe, done}, 0);
    stopCnt = 0;
    rstN = 1'b1;
    cnt = 0;
    @(negedge clk);
    while (busy && cnt < 1000) begin cnt++; @(negedge clk); end
    check(cnt == D_SS, "R1 automatic stop length", cnt, D_SS);
    check(stopCnt == 1, "R1 stop condition after reset", stopCnt, 1);
    check(doneSeen == 0, "R1 no done for automatic stop", doneSeen, 0);

    // write transaction to the target
    s0 = startCnt; p0 = stopCnt;
    runCmd(3'd1, 8'h00, 1'b0, D_SS, "R2 start timing");
    check(startCnt == s0 + 1 && stopCnt == p0, "R2 start condition", startCnt - s0, 1);
    runCmd(3'd3, {TGT_ADDR, 1'b0}, 1'b0, D_WR, "R4 write timing");
    check(monByte == {TGT_ADDR, 1'b0}, "R4 address bits msb first", monByte, {TGT_ADDR, 1'b0});
    runCmd(3'd4, 8'h00, 1'b0, D_ACK, "R5 ackchk timing");
    check(ackStatus == 1'b0, "R5 address acknowledged", ackStatus, 0);
    runCmd(3'd3, 8'h3C, 1'b0, D_WR, "R4 data write timing");
    check(tGot == 8'h3C, "R4 target received byte", tGot, 8'h3C);
    runCmd(3'd4, 8'h00, 1'b0, D_ACK, "R5 data ack timing");
    check(ackStatus == 1'b0, "R5 data acknowledged", ackStatus, 0);
    p0 = stopCnt;
    runCmd(3'd2, 8'h00, 1'b0, D_SS, "R3 stop timing");
    check(stopCnt == p0 + 1, "R3 stop condition", stopCnt - p0, 1);
    check(stabBad == 0, "R4 data stable while clock high", stabBad, 0);

    // read transaction
    runCmd(3'd1, 8'h00, 1'b0, D_SS, "R2 repeated start timing");
    runCmd(3'd3, {TGT_ADDR, 1'b1}, 1'b0, D_WR, "R4 read address timing");
    runCmd(3'd4, 8'h00, 1'b0, D_ACK, "R5 read address ack timing");
    check(ackStatus == 1'b0, "R5 read address acknowledged", ackStatus, 0);
    runCmd(3'd5, 8'h00, 1'b1, D_RD, "R6 read timing");
    check(rxByte == TGT_DATA, "R6 first byte received", rxByte, TGT_DATA);
    check(monByte[0] == 1'b0, "R6 ninth clock ack", monByte[0], 0);
    runCmd(3'd5, 8'h00, 1'b0, D_RD, "R6 last read timing");
    check(rxByte == TGT_DATA, "R6 second byte received", rxByte, TGT_DATA);
    check(monByte[0] == 1'b1, "R6 ninth clock nack", monByte[0], 1);
    p0 = stopCnt;
    runCmd(3'd2, 8'h00, 1'b0, D_SS, "R3 stop after read");
    check(stopCnt == p0 + 1, "R3 stop after read condition", stopCnt - p0, 1);

    // unknown address gives NACK
    runCmd(3'd1, 8'h00, 1'b0, D_SS, "R2 start timing 3");
    runCmd(3'd3, 8'hB0, 1'b0, D_WR, "R4 wrong address timing");
    runCmd(3'd4, 8'h00, 1'b0, D_ACK, "R5 nack timing");
    check(ackStatus == 1'b1, "R5 unknown address nack", ackStatus, 1);
    runCmd(3'd2, 8'h00, 1'b0, D_SS, "R3 stop timing 3");
    check(stabBad == 0, "R4 data stable in all byte phases", stabBad, 0);

    // R7: command while busy is dropped
    s0 = startCnt; p0 = stopCnt;
    @(negedge clk); cmdValid = 1'b1; cmdCode = 3'd1;
    @(negedge clk); cmdValid = 1'b0;
    repeat (3) @(negedge clk);
    cmdValid = 1'b1; cmdCode = 3'd2;
    @(negedge clk); cmdValid = 1'b0;
    cnt = 0;
    while (!done && cnt < 1000) begin cnt++; @(negedge clk); end
    cnt = 0;
    repeat (4) begin @(negedge clk); if (busy) cnt++; end
    check(cnt == 0 && stopCnt == p0 && startCnt == s0 + 1, "R7 command during busy ignored",
          cnt + stopCnt - p0, 0);

    // R7: unknown codes ignored
    cnt = 0;
    @(negedge clk); cmdValid = 1'b1; cmdCode = 3'd7;
    @(negedge clk); cmdValid = 1'b0;
    repeat (3) begin if (busy || done || !sclOe || !sdaOe) cnt++; @(negedge clk); end
    check(cnt == 0, "R7 code 7 ignored", cnt, 0);
    @(negedge clk); cmdValid = 1'b1; cmdCode = 3'd0;
    @(negedge clk); cmdValid = 1'b0;
    if (busy) cnt++;
    check(cnt == 0, "R7 code 0 ignored", cnt, 0);

    // R8: results held across start/stop
    runCmd(3'd2, 8'h00, 1'b0, D_SS, "R3 stop timing 4");
    runCmd(3'd1, 8'h00, 1'b0, D_SS, "R2 start timing 5");
    runCmd(3'd2, 8'h00, 1'b0, D_SS, "R3 stop timing 5");
    check(rxByte == TGT_DATA, "R8 rxByte held", rxByte, TGT_DATA);
    check(ackStatus == 1'b1, "R8 ackStatus held", ackStatus, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule